// File: doc/BRIEF.md
# Banked Control Register File with Write Masks

This block holds the system control registers of a multithreaded core. It has 256 register slots, and each slot is named by a pair made of a 5-bit register number and a 3-bit select. Every stored copy of a register has its own 32-bit write mask. A normal (masked) write from software changes only the bits that the mask enables. Every bit outside the mask keeps its present value, so read-only fields are protected without any decoding at the write port.

Registers come in three bank types:

- **Thread-owned:** one copy per hardware thread.
- **Processor-owned:** one copy per virtual processor.
- **Shared:** a single copy.

Each access carries a thread id. A thread-owned register is selected directly by that id. A processor-owned register is selected by the virtual-processor number that the thread holds in its own binding register.

The block has four ports:

- a read port with registered read data;
- a masked write port;
- a raw write port that ignores the mask, used by boot and initialisation logic;
- a mask-programming port.

A synchronous reset loads the fixed reset contents and masks.

Top module: `ctlreg_bank`

## Requirements
- R1: A masked write stores (data AND mask) OR (current AND NOT mask), using the mask of the copy it targets.
- R2: The slot index is number*8 + select, an 8-bit value. The bank types and reset values below are tied to these indices.
- R3: Indices 17 to 23, 96, 136 and 184 are thread-owned. The copy accessed is the one given by the access's thread id.
- R4: Indices 9 to 15, 49 to 53 and 121 are processor-owned. The copy accessed is the one given by the low bits (bit 0 for two processors) of the accessing thread's binding register. The binding register is the thread-owned register at index 18.
- R5: Every other index has one copy, and every thread reaches that same copy.
- R6: After reset, these indices have these masks, applied to every copy:

  | Index | Mask |
  |---|---|
  | 96 | 0xFF78FF17 |
  | 104 | 0x08C00300 |
  | 128 | 0x7FFF0007 |
  | 130 | 0x7000F000 |
  | 121 | 0x3FFFF000 |
  | 98 | 0x0000F3C0 |
  | 97 | 0x000003E0 |
  | 0 | 0x7FFFFFFF |
  | 16 and 24 | 0x3FFFFFFF |
  | 32 | 0xFF800000 |
  | 40 | 0x1FFFF800 |
  | 41 | 0x10000000 |
  | 152 | 0x7FFF0FFF |
  | 200 | 0x000007FF |

  Indices not named here or in R7 get an all-ones mask.
- R7: After reset, indices 8, 64, 120, 129, 131 and 136 have an all-zero mask, so a masked write leaves them unchanged.
- R8: After reset, these indices hold these values, and every other register is 0:

  | Index | Reset value |
  |---|---|
  | 96 | 0x00400004 (bits 22 and 2 set) |
  | 8 | 63 |
  | 121 | 0x80000000 |
  | 128 | 0x80000000 |
- R9: A raw write stores its data unmasked. If a raw write and a masked write target the same copy in one cycle, the raw data is what remains.
- R10: A mask-port write replaces the mask of the copy it resolves to. Later masked writes to that copy use the new mask.
- R11: Read data appears one cycle after the read address. If a write to the same copy happens in the same cycle, the read returns the value from before that write. Read data is 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_tid | input | TW | Thread id of the read |
| rd_idx | input | 8 | Slot index of the read |
| rd_data | output | 32 | Registered read data |
| wr_en | input | 1 | Masked write enable |
| wr_tid | input | TW | Thread id of the masked write |
| wr_idx | input | 8 | Slot index of the masked write |
| wr_data | input | 32 | Masked write data |
| raw_en | input | 1 | Raw write enable |
| raw_tid | input | TW | Thread id of the raw write |
| raw_idx | input | 8 | Slot index of the raw write |
| raw_data | input | 32 | Raw write data |
| msk_en | input | 1 | Mask write enable |
| msk_tid | input | TW | Thread id of the mask write |
| msk_idx | input | 8 | Slot index of the mask write |
| msk_data | input | 32 | New mask value |

## Verification
A wrong mask or a faulty merge shows up at the very next read of the written copy: a read-only bit changes, or a writable bit fails to change. A wrong copy selection leaves the intended copy untouched and corrupts a neighbour's copy. That second fault becomes visible as soon as the other thread, or a thread bound to the other virtual processor, reads the same index. A rebinding fault stays hidden until some processor-owned register is accessed through the rebound thread. Because every stored word is reachable, each fault shows up within one read after the first access that touches the faulty copy.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int IDX_W    = 8;
  localparam int DW       = 32;
  localparam int IDX_BIND = 18;

  typedef enum logic [1:0] {BANK_SHARED, BANK_VPE, BANK_THREAD} bank_e;

  function automatic bank_e bank_of(input logic [IDX_W-1:0] idx);
    case (idx)
      8'd17, 8'd18, 8'd19, 8'd20, 8'd21, 8'd22, 8'd23,
      8'd96, 8'd136, 8'd184:                          return BANK_THREAD;
      8'd9, 8'd10, 8'd11, 8'd12, 8'd13, 8'd14, 8'd15,
      8'd49, 8'd50, 8'd51, 8'd52, 8'd53, 8'd121:      return BANK_VPE;
      default:                                        return BANK_SHARED;
    endcase
  endfunction

  function automatic logic [DW-1:0] reset_mask(input logic [IDX_W-1:0] idx);
    case (idx)
      8'd0:         return 32'h7FFF_FFFF;
      8'd16, 8'd24: return 32'h3FFF_FFFF;
      8'd32:        return 32'hFF80_0000;
      8'd40:        return 32'h1FFF_F800;
      8'd41:        return 32'h1000_0000;
      8'd96:        return 32'hFF78_FF17;
      8'd97:        return 32'h0000_03E0;
      8'd98:        return 32'h0000_F3C0;
      8'd104:       return 32'h08C0_0300;
      8'd121:       return 32'h3FFF_F000;
      8'd128:       return 32'h7FFF_0007;
      8'd130:       return 32'h7000_F000;
      8'd152:       return 32'h7FFF_0FFF;
      8'd200:       return 32'h0000_07FF;
      8'd8, 8'd64, 8'd120, 8'd129, 8'd131, 8'd136: return '0;
      default:      return '1;
    endcase
  endfunction

  function automatic logic [DW-1:0] reset_value(input logic [IDX_W-1:0] idx);
    case (idx)
      8'd8:          return 32'd63;
      8'd96:         return 32'h0040_0004;
      8'd121, 8'd128: return 32'h8000_0000;
      default:       return '0;
    endcase
  endfunction
endpackage

// File: rtl/ctlreg_locate.sv
module ctlreg_locate
  import ctlreg_pkg::*;
#(
  parameter int NTHREAD = 2,
  parameter int TW      = 1,
  parameter int VW      = 1,
  parameter int CW      = 1
) (
  input  logic [IDX_W-1:0]            idx,
  input  logic [TW-1:0]               tid,
  input  logic [NTHREAD-1:0][VW-1:0]  bind_vpe,
  output logic [CW+IDX_W-1:0]         slot
);
  logic [CW-1:0] copy;

  always_comb begin
    case (bank_of(idx))
      BANK_THREAD: copy = CW'(tid);
      BANK_VPE:    copy = CW'(bind_vpe[tid]);
      default:     copy = '0;
    endcase
    slot = {copy, idx};
  end
endmodule

// File: rtl/ctlreg_merge.sv
module ctlreg_merge
  import ctlreg_pkg::*;
(
  input  logic [DW-1:0] new_val,
  input  logic [DW-1:0] cur_val,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] merged
);
  always_comb merged = (new_val & mask) | (cur_val & ~mask);
endmodule

// File: rtl/ctlreg_store.sv
module ctlreg_store
  import ctlreg_pkg::*;
#(
  parameter int NTHREAD = 2,
  parameter int VW      = 1,
  parameter int CW      = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CW+IDX_W-1:0]        rd_slot,
  output logic [DW-1:0]              rd_q,
  input  logic [CW+IDX_W-1:0]        wr_slot,
  output logic [DW-1:0]              old_dat,
  output logic [DW-1:0]              old_msk,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_dat,
  input  logic                       raw_en,
  input  logic [CW+IDX_W-1:0]        raw_slot,
  input  logic [DW-1:0]              raw_dat,
  input  logic                       mk_en,
  input  logic [CW+IDX_W-1:0]        mk_slot,
  input  logic [DW-1:0]              mk_dat,
  output logic [NTHREAD-1:0][VW-1:0] bind_vpe
);
  localparam int NSLOT = (1 << CW) << IDX_W;

  logic [DW-1:0] dat_mem [NSLOT];
  logic [DW-1:0] msk_mem [NSLOT];

  assign old_dat = dat_mem[wr_slot];
  assign old_msk = msk_mem[wr_slot];

  for (genvar t = 0; t < NTHREAD; t++) begin : g_bind
    localparam int BSLOT = (t << IDX_W) + IDX_BIND;
    assign bind_vpe[t] = dat_mem[BSLOT][VW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
      for (int s = 0; s < NSLOT; s++) begin
        dat_mem[s] <= reset_value(IDX_W'(s));
        msk_mem[s] <= reset_mask(IDX_W'(s));
      end
    end else begin
      rd_q <= dat_mem[rd_slot];
      if (wr_en)  dat_mem[wr_slot]  <= wr_dat;
      if (raw_en) dat_mem[raw_slot] <= raw_dat;
      if (mk_en)  msk_mem[mk_slot]  <= mk_dat;
    end
  end
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter int NTHREAD = 2,
  parameter int NVPE    = 2,
  localparam int TW = (NTHREAD > 1) ? $clog2(NTHREAD) : 1,
  localparam int VW = (NVPE > 1) ? $clog2(NVPE) : 1,
  localparam int CW = (TW > VW) ? TW : VW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TW-1:0]    rd_tid,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  input  logic             wr_en,
  input  logic [TW-1:0]    wr_tid,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             raw_en,
  input  logic [TW-1:0]    raw_tid,
  input  logic [IDX_W-1:0] raw_idx,
  input  logic [DW-1:0]    raw_data,
  input  logic             msk_en,
  input  logic [TW-1:0]    msk_tid,
  input  logic [IDX_W-1:0] msk_idx,
  input  logic [DW-1:0]    msk_data
);
  localparam int NPORT = 4;
  localparam int SW    = CW + IDX_W;

  logic [NPORT-1:0][IDX_W-1:0] p_idx;
  logic [NPORT-1:0][TW-1:0]    p_tid;
  logic [NPORT-1:0][SW-1:0]    p_slot;
  logic [NTHREAD-1:0][VW-1:0]  bind_vpe;
  logic [SW-1:0]               rd_slot, wr_slot, raw_slot, mk_slot;
  logic [DW-1:0]               old_dat, old_msk, merged;

  assign p_idx = {msk_idx, raw_idx, wr_idx, rd_idx};
  assign p_tid = {msk_tid, raw_tid, wr_tid, rd_tid};

  for (genvar p = 0; p < NPORT; p++) begin : g_loc
    ctlreg_locate #(.NTHREAD(NTHREAD), .TW(TW), .VW(VW), .CW(CW)) u_loc (
      .idx      (p_idx[p]),
      .tid      (p_tid[p]),
      .bind_vpe (bind_vpe),
      .slot     (p_slot[p])
    );
  end

  assign rd_slot  = p_slot[0];
  assign wr_slot  = p_slot[1];
  assign raw_slot = p_slot[2];
  assign mk_slot  = p_slot[3];

  ctlreg_merge u_merge (
    .new_val (wr_data),
    .cur_val (old_dat),
    .mask    (old_msk),
    .merged  (merged)
  );

  ctlreg_store #(.NTHREAD(NTHREAD), .VW(VW), .CW(CW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .rd_slot  (rd_slot),
    .rd_q     (rd_data),
    .wr_slot  (wr_slot),
    .old_dat  (old_dat),
    .old_msk  (old_msk),
    .wr_en    (wr_en),
    .wr_dat   (merged),
    .raw_en   (raw_en),
    .raw_slot (raw_slot),
    .raw_dat  (raw_data),
    .mk_en    (msk_en),
    .mk_slot  (mk_slot),
    .mk_dat   (msk_data),
    .bind_vpe (bind_vpe)
  );
endmodule

// File: rtl/ctlreg_bank_chk.sv
module ctlreg_bank_chk
  import ctlreg_pkg::*;
#(
  parameter int TW = 1,
  parameter int CW = 1
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                raw_en,
  input logic [TW-1:0]       wr_tid,
  input logic [IDX_W-1:0]    wr_idx,
  input logic [DW-1:0]       wr_data,
  input logic [DW-1:0]       rd_data,
  input logic [CW+IDX_W-1:0] wr_slot,
  input logic [CW+IDX_W-1:0] rd_slot,
  input logic [DW-1:0]       merged,
  input logic [DW-1:0]       old_dat,
  input logic [DW-1:0]       old_msk
);
  localparam int SW = CW + IDX_W;

  a_r1_keep_locked: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (((merged ^ old_dat) & ~old_msk) == '0));

  a_r1_take_open: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (((merged ^ wr_data) & old_msk) == '0));

  a_r3_thread_copy: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bank_of(wr_idx) == BANK_THREAD) |-> (wr_slot[SW-1:IDX_W] == CW'(wr_tid)));

  a_r5_shared_copy: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bank_of(wr_idx) == BANK_SHARED) |-> (wr_slot[SW-1:IDX_W] == '0));

  a_r11_reset_zero: assert property (@(posedge clk)
    rst |=> (rd_data == '0));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rd_slot == $past(rd_slot) && !$past(wr_en) && !$past(raw_en))
      |=> $stable(rd_data));
endmodule

bind ctlreg_bank ctlreg_bank_chk #(.TW(TW), .CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .raw_en  (raw_en),
  .wr_tid  (wr_tid),
  .wr_idx  (wr_idx),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .wr_slot (wr_slot),
  .rd_slot (rd_slot),
  .merged  (merged),
  .old_dat (old_dat),
  .old_msk (old_msk)
);

// File: tb/ctlreg_bank_tb.sv
module ctlreg_bank_tb;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        rd_tid = 0;
  logic [7:0]  rd_idx = 0;
  logic [31:0] rd_data;
  logic        wr_en = 0;
  logic        wr_tid = 0;
  logic [7:0]  wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic        raw_en = 0;
  logic        raw_tid = 0;
  logic [7:0]  raw_idx = 0;
  logic [31:0] raw_data = 0;
  logic        msk_en = 0;
  logic        msk_tid = 0;
  logic [7:0]  msk_idx = 0;
  logic [31:0] msk_data = 0;

  int checks = 0;
  int failures = 0;

  logic [31:0] m_dat [2][256];
  logic [31:0] m_msk [2][256];

  always #(CLK_P/2) clk = ~clk;

  ctlreg_bank u_dut (
    .clk(clk), .rst(rst),
    .rd_tid(rd_tid), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_tid(wr_tid), .wr_idx(wr_idx), .wr_data(wr_data),
    .raw_en(raw_en), .raw_tid(raw_tid), .raw_idx(raw_idx), .raw_data(raw_data),
    .msk_en(msk_en), .msk_tid(msk_tid), .msk_idx(msk_idx), .msk_data(msk_data)
  );

  // Bank kind from the requirement lists: 2 = thread, 1 = processor, 0 = shared.
  function automatic int kind(input int i);
    if ((i >= 17 && i <= 23) || i == 96 || i == 136 || i == 184) return 2;
    if ((i >= 9 && i <= 15) || (i >= 49 && i <= 53) || i == 121) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] exp_mask(input int i);
    case (i)
      96: return 32'hFF78FF17;   104: return 32'h08C00300;
      128: return 32'h7FFF0007;  130: return 32'h7000F000;
      121: return 32'h3FFFF000;  98: return 32'h0000F3C0;
      97: return 32'h000003E0;   0: return 32'h7FFFFFFF;
      16, 24: return 32'h3FFFFFFF;
      32: return 32'hFF800000;   40: return 32'h1FFFF800;
      41: return 32'h10000000;   152: return 32'h7FFF0FFF;
      200: return 32'h000007FF;
      8, 64, 120, 129, 131, 136: return 32'h0;
      default: return 32'hFFFFFFFF;
    endcase
  endfunction

  function automatic logic [31:0] exp_rval(input int i);
    case (i)
      96: return 32'h00400004;
      8: return 32'd63;
      121, 128: return 32'h80000000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int copy_of(input int t, input int i);
    if (kind(i) == 2) return t;
    if (kind(i) == 1) return int'(m_dat[t][18][0]);
    return 0;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 256; i++) begin
        m_dat[c][i] = exp_rval(i);
        m_msk[c][i] = exp_mask(i);
      end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input int t, input int i, input string req);
    rd_tid = t[0]; rd_idx = i[7:0];
    @(posedge clk); #1;
    check(req, rd_data, m_dat[copy_of(t, i)][i]);
  endtask

  task automatic mwrite(input int t, input int i, input logic [31:0] d);
    int c;
    c = copy_of(t, i);
    wr_en = 1; wr_tid = t[0]; wr_idx = i[7:0]; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
    m_dat[c][i] = (d & m_msk[c][i]) | (m_dat[c][i] & ~m_msk[c][i]);
  endtask

  task automatic rwrite(input int t, input int i, input logic [31:0] d);
    int c;
    c = copy_of(t, i);
    raw_en = 1; raw_tid = t[0]; raw_idx = i[7:0]; raw_data = d;
    @(posedge clk); #1;
    raw_en = 0;
    m_dat[c][i] = d;
  endtask

  task automatic kwrite(input int t, input int i, input logic [31:0] d);
    int c;
    c = copy_of(t, i);
    msk_en = 1; msk_tid = t[0]; msk_idx = i[7:0]; msk_data = d;
    @(posedge clk); #1;
    msk_en = 0;
    m_msk[c][i] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset read zero", rd_data, 32'h0);
    rst = 0;

    // R2 R6 R8: reset contents at every index, both threads
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 256; i++) rd_chk(t, i, "R2/R8 reset value");

    // R1 R6 R7: sweep masked all-ones then all-zeros writes through each thread
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 256; i++) begin
        mwrite(t, i, 32'hFFFFFFFF);
        rd_chk(t, i, "R1/R6/R7 masked ones");
        mwrite(t, i, 32'h00000000);
        rd_chk(t, i, "R1/R6 masked zeros");
      end

    // R3: thread-owned copies are separate
    mwrite(1, 96, 32'h12345678);
    rd_chk(0, 96, "R3 thread0 copy untouched");
    rd_chk(1, 96, "R3 thread1 copy written");

    // R5: shared copy seen by both threads
    mwrite(1, 72, 32'hCAFE0001);
    rd_chk(0, 72, "R5 shared copy");

    // R4: processor-owned copy via binding
    rwrite(1, 18, 32'h1);
    mwrite(1, 121, 32'h3ABCD000);
    rd_chk(0, 121, "R4 vpe0 copy untouched");
    rd_chk(1, 121, "R4 vpe1 copy written");
    rwrite(0, 18, 32'h1);
    rd_chk(0, 121, "R4 rebound thread0 sees vpe1");
    rwrite(0, 18, 32'h0);
    rd_chk(0, 121, "R4 back on vpe0");

    // R9: raw write ignores mask; raw wins on same copy
    rwrite(0, 120, 32'hA5A55A5A);
    rd_chk(1, 120, "R9 raw into read-only");
    wr_en = 1; wr_tid = 0; wr_idx = 8'd72; wr_data = 32'h11111111;
    raw_en = 1; raw_tid = 1; raw_idx = 8'd72; raw_data = 32'h22222222;
    @(posedge clk); #1;
    wr_en = 0; raw_en = 0;
    m_dat[0][72] = 32'h22222222;
    rd_chk(0, 72, "R9 raw wins");

    // R10: mask port
    kwrite(0, 72, 32'h0000FFFF);
    mwrite(1, 72, 32'hFFFF0000);
    rd_chk(0, 72, "R10 new mask upper");
    mwrite(0, 72, 32'h0000BEEF);
    rd_chk(0, 72, "R10 new mask lower");
    kwrite(1, 96, 32'h0);
    mwrite(1, 96, 32'hFFFFFFFF);
    rd_chk(1, 96, "R10 thread1 mask zeroed");
    mwrite(0, 96, 32'hFFFFFFFF);
    rd_chk(0, 96, "R10 thread0 mask kept");

    // R11: read in the same cycle as a write returns the old value
    rd_tid = 0; rd_idx = 8'd80;
    wr_en = 1; wr_tid = 0; wr_idx = 8'd80; wr_data = 32'h0BADF00D;
    @(posedge clk); #1;
    wr_en = 0;
    check("R11 read before write", rd_data, m_dat[0][80]);
    m_dat[0][80] = 32'h0BADF00D;
    rd_chk(0, 80, "R11 read after write");

    // R8: reset restores contents
    rst = 1;
    @(posedge clk); #1;
    rst = 0;
    model_reset();
    rd_chk(0, 72, "R8 reset after writes");
    rd_chk(1, 96, "R8 status reset");
    rd_chk(0, 8, "R8 random reset");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule